// File: doc/BRIEF.md
# Quick DMA Trigger and Completion Controller

This block is the control front end for a small group of quick DMA channels. Each channel is bound by a map register to one parameter slot and to one 32-bit word inside that slot. The block watches the write traffic that goes into parameter memory. When a write lands on the bound word of a channel that is enabled, it raises a transfer request for that channel. The block does not move data and does not hold the parameter memory itself.

Each channel has three flags: an event enable, a secondary flag that shows a transfer is in flight, and a missed-event flag. A trigger that arrives while the secondary flag is still set is recorded as missed and does not start a transfer. The transfer engine clears the secondary flag through a per-channel acknowledge. When it reports a completion code, the block sets a bit in a 64-bit pending vector. Software reads the vector as two 32-bit halves and clears it by writing ones.

All registers sit on a simple 32-bit register bus. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `qdma_trigger_ctrl`

## Requirements
- R1: After reset every register reads zero and `xfer_req` is all zero.
- R2: The map register of channel n is at offset 4*n. It keeps the slot number in bits 13:5 and the word index in bits 4:2. All other bits read zero.
- R3: A trigger is a snoop write whose `pr_addr` has bits 15:14 = 01, bits 13:5 equal to a channel's slot and bits 4:2 equal to its word. If that channel is enabled and its secondary flag is clear, the trigger drives `xfer_req[n]` high for exactly the one cycle after the write edge and sets the secondary flag.
- R4: A trigger on an enabled channel whose secondary flag is already set sets that channel's missed flag and issues no request.
- R5: A snoop write is ignored, with no request and no flag change, in three cases: the channel is disabled, the word or slot differs, or bits 15:14 are not 01.
- R6: A map register holding zero leaves its channel unbound, so no address triggers it.
- R7: A write to the enable-set register (0x44) sets, and a write to the enable-clear register (0x48) clears, exactly the channels whose bits are 1. The enable status reads at 0x40.
- R8: The secondary flag (status 0x50) is cleared by `xfer_ack[n]` or by writing 1 to 0x54. The missed flag (status 0x58) is cleared by writing 1 to 0x5C. A set beats a clear in the same cycle.
- R9: A `done_valid` strobe sets pending bit `done_code`. Codes 0 to 31 read at 0x60, bit code. Codes 32 to 63 read at 0x64, bit code-32.
- R10: Writing ones to 0x68 (low half) or 0x6C (high half) clears the matching pending bits and no others. A completion strobe in the same cycle wins.
- R11: Channels that share a trigger word all fire on one snoop write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pr_wr | input | 1 | Parameter memory write seen on the snoop port |
| pr_addr | input | 16 | Byte address of the snooped write |
| xfer_req | output | 8 | One-cycle transfer request per channel |
| xfer_ack | input | 8 | Per-channel acknowledge from the transfer engine |
| done_valid | input | 1 | Completion strobe |
| done_code | input | 6 | Completion code |

## Verification
The effects of a register write, snoop write, acknowledge or completion strobe are all captured at the rising edge that samples them. The status they produce can therefore be read one cycle later. A request shows on `xfer_req` in the cycle after its snoop edge and is low again one cycle after that. The bench applies each stimulus for one cycle from a falling edge. It checks the request at the next falling edge, then checks that the request has dropped one cycle later. It reads status combinationally while the clock is low, so no sample coincides with a rising edge.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  localparam int REG_W  = 32;
  localparam int PEND_N = 64;
  localparam int CODE_W = 6;

  localparam logic [7:0] OFF_EN_STAT   = 8'h40;
  localparam logic [7:0] OFF_EN_SET    = 8'h44;
  localparam logic [7:0] OFF_EN_CLR    = 8'h48;
  localparam logic [7:0] OFF_SEC_STAT  = 8'h50;
  localparam logic [7:0] OFF_SEC_CLR   = 8'h54;
  localparam logic [7:0] OFF_MISS_STAT = 8'h58;
  localparam logic [7:0] OFF_MISS_CLR  = 8'h5C;
  localparam logic [7:0] OFF_PEND_LO   = 8'h60;
  localparam logic [7:0] OFF_PEND_HI   = 8'h64;
  localparam logic [7:0] OFF_PCLR_LO   = 8'h68;
  localparam logic [7:0] OFF_PCLR_HI   = 8'h6C;
endpackage

// File: rtl/qdma_regif.sv
module qdma_regif
  import qdma_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int ADDR_W  = 16,
  parameter int SLOT_W  = 9,
  parameter int SLOT_SH = 5,
  parameter int WORD_W  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_wr_i,
  input  logic [ADDR_W-1:0]                reg_addr_i,
  input  logic [REG_W-1:0]                 reg_wdata_i,
  output logic [REG_W-1:0]                 reg_rdata_o,
  input  logic [NUM_CH-1:0]                en_q_i,
  input  logic [NUM_CH-1:0]                sec_q_i,
  input  logic [NUM_CH-1:0]                miss_q_i,
  input  logic [PEND_N-1:0]                pend_q_i,
  output logic [NUM_CH-1:0][SLOT_W-1:0]    map_slot_o,
  output logic [NUM_CH-1:0][WORD_W-1:0]    map_word_o,
  output logic [NUM_CH-1:0]                en_set_o,
  output logic [NUM_CH-1:0]                en_clr_o,
  output logic [NUM_CH-1:0]                sec_clr_o,
  output logic [NUM_CH-1:0]                miss_clr_o,
  output logic [PEND_N-1:0]                pend_clr_o
);
  localparam int HALF = PEND_N / 2;

  logic       page_ok;
  logic [7:0] off;
  logic [NUM_CH-1:0] map_we;

  assign page_ok = (reg_addr_i[ADDR_W-1:8] == '0);
  assign off     = reg_addr_i[7:0];

  // write strobes for the set and clear registers
  always_comb begin
    en_set_o   = '0;
    en_clr_o   = '0;
    sec_clr_o  = '0;
    miss_clr_o = '0;
    pend_clr_o = '0;
    if (reg_wr_i && page_ok) begin
      unique case (off)
        OFF_EN_SET:   en_set_o   = reg_wdata_i[NUM_CH-1:0];
        OFF_EN_CLR:   en_clr_o   = reg_wdata_i[NUM_CH-1:0];
        OFF_SEC_CLR:  sec_clr_o  = reg_wdata_i[NUM_CH-1:0];
        OFF_MISS_CLR: miss_clr_o = reg_wdata_i[NUM_CH-1:0];
        OFF_PCLR_LO:  pend_clr_o[HALF-1:0]      = reg_wdata_i[HALF-1:0];
        OFF_PCLR_HI:  pend_clr_o[PEND_N-1:HALF] = reg_wdata_i[HALF-1:0];
        default: ;
      endcase
    end
  end

  // per-channel map registers
  for (genvar i = 0; i < NUM_CH; i++) begin : g_map
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [WORD_W-1:0] word_q, word_d;

    assign map_we[i] = reg_wr_i && page_ok && (off == 8'(i * 4));

    always_comb begin
      slot_d = reg_wdata_i[SLOT_SH +: SLOT_W];
      word_d = reg_wdata_i[2 +: WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
        word_q <= '0;
      end else if (map_we[i]) begin
        slot_q <= slot_d;
        word_q <= word_d;
      end
    end

    assign map_slot_o[i] = slot_q;
    assign map_word_o[i] = word_q;
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (page_ok) begin
      unique case (off)
        OFF_EN_STAT:   reg_rdata_o = REG_W'(en_q_i);
        OFF_SEC_STAT:  reg_rdata_o = REG_W'(sec_q_i);
        OFF_MISS_STAT: reg_rdata_o = REG_W'(miss_q_i);
        OFF_PEND_LO:   reg_rdata_o = pend_q_i[HALF-1:0];
        OFF_PEND_HI:   reg_rdata_o = pend_q_i[PEND_N-1:HALF];
        default: begin
          for (int i = 0; i < NUM_CH; i++) begin
            if (off == 8'(i * 4)) begin
              reg_rdata_o = (REG_W'(map_slot_o[i]) << SLOT_SH) |
                            (REG_W'(map_word_o[i]) << 2);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/qdma_trig_match.sv
module qdma_trig_match #(
  parameter int          NUM_CH  = 8,
  parameter int          ADDR_W  = 16,
  parameter int          SLOT_W  = 9,
  parameter int          SLOT_SH = 5,
  parameter int          WORD_W  = 3,
  parameter logic [15:0] PR_BASE = 16'h4000
) (
  input  logic                          pr_wr_i,
  input  logic [ADDR_W-1:0]             pr_addr_i,
  input  logic [NUM_CH-1:0][SLOT_W-1:0] map_slot_i,
  input  logic [NUM_CH-1:0][WORD_W-1:0] map_word_i,
  output logic [NUM_CH-1:0]             hit_o
);
  localparam int WIN_LSB = SLOT_SH + SLOT_W;
  localparam int WIN_W   = ADDR_W - WIN_LSB;
  localparam logic [WIN_W-1:0] WIN_TAG = WIN_W'(PR_BASE >> WIN_LSB);

  logic              in_win;
  logic [SLOT_W-1:0] a_slot;
  logic [WORD_W-1:0] a_word;
  logic              unused_lo;

  assign in_win    = pr_wr_i && (pr_addr_i[ADDR_W-1:WIN_LSB] == WIN_TAG);
  assign a_slot    = pr_addr_i[SLOT_SH +: SLOT_W];
  assign a_word    = pr_addr_i[2 +: WORD_W];
  assign unused_lo = ^pr_addr_i[1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    logic bound;
    assign bound    = |{map_slot_i[i], map_word_i[i]};
    assign hit_o[i] = in_win && bound &&
                      (a_slot == map_slot_i[i]) && (a_word == map_word_i[i]);
  end
endmodule

// File: rtl/qdma_chan_flags.sv
module qdma_chan_flags #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic [NUM_CH-1:0] en_set_i,
  input  logic [NUM_CH-1:0] en_clr_i,
  input  logic [NUM_CH-1:0] sec_clr_i,
  input  logic [NUM_CH-1:0] miss_clr_i,
  input  logic [NUM_CH-1:0] ack_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] sec_o,
  output logic [NUM_CH-1:0] miss_o,
  output logic [NUM_CH-1:0] req_o
);
  logic [NUM_CH-1:0] en_q, en_d, sec_q, sec_d, miss_q, miss_d, req_q, req_d;
  logic [NUM_CH-1:0] fire, busy;

  always_comb begin
    fire   = hit_i & en_q & ~sec_q;
    busy   = hit_i & en_q & sec_q;
    en_d   = (en_q | en_set_i) & ~en_clr_i;
    sec_d  = fire | (sec_q & ~(ack_i | sec_clr_i));
    miss_d = busy | (miss_q & ~miss_clr_i);
    req_d  = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sec_q  <= '0;
      miss_q <= '0;
      req_q  <= '0;
    end else begin
      en_q   <= en_d;
      sec_q  <= sec_d;
      miss_q <= miss_d;
      req_q  <= req_d;
    end
  end

  assign en_o   = en_q;
  assign sec_o  = sec_q;
  assign miss_o = miss_q;
  assign req_o  = req_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R3
    req_holds_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q[i] |-> sec_q[i]);
    // R3
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q[i] |=> !req_q[i]);
    // R4
    busy_trig_missed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i[i] && en_q[i] && sec_q[i]) |=> (miss_q[i] && !req_q[i]));
    // R5
    disabled_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i[i] && !en_q[i]) |=> !req_q[i]);
    // R8
    ack_clears_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[i] && !hit_i[i]) |=> !sec_q[i]);
  end
endmodule

// File: rtl/qdma_done_pend.sv
module qdma_done_pend
  import qdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_valid_i,
  input  logic [CODE_W-1:0] done_code_i,
  input  logic [PEND_N-1:0] clr_i,
  output logic [PEND_N-1:0] pend_o
);
  logic [PEND_N-1:0] pend_q, pend_d, set_vec;
  logic              upd;

  always_comb begin
    set_vec = '0;
    if (done_valid_i) set_vec[done_code_i] = 1'b1;
    pend_d = (pend_q & ~clr_i) | set_vec;
    upd    = done_valid_i | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R9
  done_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid_i |=> pend_q[$past(done_code_i)]);
endmodule

// File: rtl/qdma_trigger_ctrl.sv
module qdma_trigger_ctrl
  import qdma_pkg::*;
#(
  parameter int          NUM_CH     = 8,
  parameter int          ADDR_W     = 16,
  parameter int          SLOT_CNT   = 512,
  parameter int          SLOT_BYTES = 32,
  parameter logic [15:0] PR_BASE    = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              pr_wr,
  input  logic [ADDR_W-1:0] pr_addr,
  output logic [NUM_CH-1:0] xfer_req,
  input  logic [NUM_CH-1:0] xfer_ack,
  input  logic              done_valid,
  input  logic [CODE_W-1:0] done_code
);
  localparam int SLOT_W  = $clog2(SLOT_CNT);
  localparam int SLOT_SH = $clog2(SLOT_BYTES);
  localparam int WORD_W  = SLOT_SH - 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NUM_CH-1:0][SLOT_W-1:0] map_slot;
  logic [NUM_CH-1:0][WORD_W-1:0] map_word;
  logic [NUM_CH-1:0] en_set, en_clr, sec_clr, miss_clr;
  logic [NUM_CH-1:0] en_q, sec_q, miss_q, hit;
  logic [PEND_N-1:0] pend_q, pend_clr;

  qdma_regif #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W),
    .SLOT_SH(SLOT_SH), .WORD_W(WORD_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n_int),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .en_q_i(en_q), .sec_q_i(sec_q), .miss_q_i(miss_q), .pend_q_i(pend_q),
    .map_slot_o(map_slot), .map_word_o(map_word),
    .en_set_o(en_set), .en_clr_o(en_clr), .sec_clr_o(sec_clr),
    .miss_clr_o(miss_clr), .pend_clr_o(pend_clr)
  );

  qdma_trig_match #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W),
    .SLOT_SH(SLOT_SH), .WORD_W(WORD_W), .PR_BASE(PR_BASE)
  ) u_match (
    .pr_wr_i(pr_wr), .pr_addr_i(pr_addr),
    .map_slot_i(map_slot), .map_word_i(map_word), .hit_o(hit)
  );

  qdma_chan_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst_n(rst_n_int), .hit_i(hit),
    .en_set_i(en_set), .en_clr_i(en_clr), .sec_clr_i(sec_clr),
    .miss_clr_i(miss_clr), .ack_i(xfer_ack),
    .en_o(en_q), .sec_o(sec_q), .miss_o(miss_q), .req_o(xfer_req)
  );

  qdma_done_pend u_pend (
    .clk(clk), .rst_n(rst_n_int),
    .done_valid_i(done_valid), .done_code_i(done_code),
    .clr_i(pend_clr), .pend_o(pend_q)
  );
endmodule

// File: tb/qdma_trigger_ctrl_bench.sv
module qdma_trigger_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pr_wr;
  logic [15:0] pr_addr;
  logic [7:0]  xfer_req;
  logic [7:0]  xfer_ack;
  logic        done_valid;
  logic [5:0]  done_code;

  int vectors = 0;
  int miscompares = 0;

  qdma_trigger_ctrl u_qdma_trigger_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pr_wr(pr_wr),
    .pr_addr(pr_addr), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
    .done_valid(done_valid), .done_code(done_code)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] trig_addr(input int slot, input int word);
    return 16'h4000 | 16'(slot << 5) | 16'(word << 2);
  endfunction

  function automatic logic [31:0] map_val(input int slot, input int word);
    return 32'(slot << 5) | 32'(word << 2);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    pr_wr = 0; pr_addr = 0; xfer_ack = 0; done_valid = 0; done_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic snoop(input logic [15:0] a);
    @(negedge clk);
    pr_wr = 1'b1; pr_addr = a;
    @(negedge clk);
    pr_wr = 1'b0;
  endtask

  task automatic ack(input logic [7:0] m);
    @(negedge clk);
    xfer_ack = m;
    @(negedge clk);
    xfer_ack = 0;
  endtask

  task automatic done(input logic [5:0] c);
    @(negedge clk);
    done_valid = 1'b1; done_code = c;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 xfer_req", 32'(xfer_req), 0);
    rd_chk("R1 map0", 16'h0000, 0);
    rd_chk("R1 map7", 16'h001C, 0);
    rd_chk("R1 enable", 16'h0040, 0);
    rd_chk("R1 secondary", 16'h0050, 0);
    rd_chk("R1 missed", 16'h0058, 0);
    rd_chk("R1 pend lo", 16'h0060, 0);
    rd_chk("R1 pend hi", 16'h0064, 0);
  endtask

  task automatic t_map_fields();
    do_reset();
    wr(16'h0010, 32'hFFFF_FFFF);
    rd_chk("R2 map4 field mask", 16'h0010, 32'h0000_3FFC);
    wr(16'h001C, 32'h0000_00A4);
    rd_chk("R2 map7 readback", 16'h001C, 32'h0000_00A4);
    rd_chk("R2 map6 untouched", 16'h0018, 0);
  endtask

  task automatic t_trigger();
    do_reset();
    wr(16'h0008, map_val(5, 7));
    wr(16'h0044, 32'h04);
    snoop(trig_addr(5, 7));
    check("R3 request pulse", 32'(xfer_req), 32'h04);
    rd_chk("R3 secondary set", 16'h0050, 32'h04);
    @(negedge clk);
    check("R3 request one cycle", 32'(xfer_req), 0);
    snoop(trig_addr(5, 7));
    check("R4 no request while busy", 32'(xfer_req), 0);
    rd_chk("R4 missed set", 16'h0058, 32'h04);
    rd_chk("R4 secondary kept", 16'h0050, 32'h04);
    ack(8'h04);
    rd_chk("R8 ack clears secondary", 16'h0050, 0);
    wr(16'h005C, 32'h04);
    rd_chk("R8 missed W1C", 16'h0058, 0);
    snoop(trig_addr(5, 7));
    check("R3 request after ack", 32'(xfer_req), 32'h04);
    wr(16'h0054, 32'h04);
    rd_chk("R8 secondary W1C", 16'h0050, 0);
  endtask

  task automatic t_set_wins();
    do_reset();
    wr(16'h0000, map_val(20, 1));
    wr(16'h0044, 32'h01);
    @(negedge clk);
    pr_wr = 1'b1; pr_addr = trig_addr(20, 1);
    reg_wr = 1'b1; reg_addr = 16'h0054; reg_wdata = 32'h01;
    @(negedge clk);
    pr_wr = 1'b0; reg_wr = 1'b0;
    check("R8 set beats clear req", 32'(xfer_req), 32'h01);
    rd_chk("R8 set beats clear flag", 16'h0050, 32'h01);
  endtask

  task automatic t_ignore();
    do_reset();
    wr(16'h000C, map_val(9, 0));
    snoop(trig_addr(9, 0));
    check("R5 disabled ignored", 32'(xfer_req), 0);
    rd_chk("R5 disabled no secondary", 16'h0050, 0);
    rd_chk("R5 disabled no missed", 16'h0058, 0);
    wr(16'h0044, 32'h08);
    snoop(trig_addr(9, 1));
    check("R5 wrong word", 32'(xfer_req), 0);
    snoop(trig_addr(8, 0));
    check("R5 wrong slot", 32'(xfer_req), 0);
    snoop(16'h0120);
    check("R5 below window", 32'(xfer_req), 0);
    snoop(16'hC120);
    check("R5 above window", 32'(xfer_req), 0);
    rd_chk("R5 no flags after misses", 16'h0050, 0);
    wr(16'h0048, 32'h08);
    rd_chk("R7 enable cleared", 16'h0040, 0);
    snoop(trig_addr(9, 0));
    check("R5 after disable", 32'(xfer_req), 0);
  endtask

  task automatic t_unbind();
    do_reset();
    wr(16'h0004, map_val(0, 1));
    wr(16'h0044, 32'h02);
    snoop(trig_addr(0, 1));
    check("R6 bound fires", 32'(xfer_req), 32'h02);
    ack(8'h02);
    wr(16'h0004, 32'h0);
    snoop(trig_addr(0, 1));
    check("R6 unbound old word", 32'(xfer_req), 0);
    snoop(trig_addr(0, 0));
    check("R6 unbound slot0 word0", 32'(xfer_req), 0);
  endtask

  task automatic t_enable_bits();
    do_reset();
    wr(16'h0044, 32'h01);
    rd_chk("R7 set ch0", 16'h0040, 32'h01);
    wr(16'h0044, 32'h20);
    rd_chk("R7 set ch5 keeps ch0", 16'h0040, 32'h21);
    wr(16'h0048, 32'h01);
    rd_chk("R7 clear ch0 only", 16'h0040, 32'h20);
    wr(16'h0048, 32'h00);
    rd_chk("R7 zero clear no effect", 16'h0040, 32'h20);
  endtask

  task automatic t_multi();
    do_reset();
    wr(16'h0000, map_val(100, 3));
    wr(16'h0004, map_val(100, 3));
    wr(16'h0044, 32'h03);
    snoop(trig_addr(100, 3));
    check("R11 shared word fires both", 32'(xfer_req), 32'h03);
    rd_chk("R11 both secondary", 16'h0050, 32'h03);
  endtask

  task automatic t_pending();
    do_reset();
    done(6'd3);
    rd_chk("R9 code3 low", 16'h0060, 32'h0000_0008);
    rd_chk("R9 code3 high clear", 16'h0064, 0);
    done(6'd40);
    rd_chk("R9 code40 high", 16'h0064, 32'h0000_0100);
    done(6'd63);
    rd_chk("R9 code63 high", 16'h0064, 32'h8000_0100);
    wr(16'h0068, 32'h0000_0008);
    rd_chk("R10 low W1C", 16'h0060, 0);
    wr(16'h006C, 32'h0000_0100);
    rd_chk("R10 high W1C selective", 16'h0064, 32'h8000_0000);
    @(negedge clk);
    done_valid = 1'b1; done_code = 6'd40;
    reg_wr = 1'b1; reg_addr = 16'h006C; reg_wdata = 32'h0000_0100;
    @(negedge clk);
    done_valid = 1'b0; reg_wr = 1'b0;
    rd_chk("R10 strobe beats clear", 16'h0064, 32'h8000_0100);
  endtask

  initial begin
    t_reset();
    t_map_fields();
    t_trigger();
    t_set_wins();
    t_ignore();
    t_unbind();
    t_enable_bits();
    t_multi();
    t_pending();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule